// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory

This block is a word-organised memory with 16-bit data, addressed by byte and accessed only on even addresses, whose storage is split into four banks that run on independent timing. Consecutive words land in consecutive banks, so a stream of sequential requests can be issued on every clock without any of them waiting. Each access occupies its bank for a fixed window. A read returns its word two cycles after the request. A write stores its word in the array when its bank window ends.

A request that targets a bank that is still inside its window is not queued. The block drops it and raises `stall` in the same cycle, so the requester can retry. A misaligned request, or one that asks for a read and a write together, is refused and flagged on `err`. A refused request never occupies a bank. One flag per bank on `bank_busy` lets the requester avoid conflicts in advance. Reset empties the bank windows and clears the whole array to zero. The default `ADDR_W` of 12 gives a 4 KB array, and setting `ADDR_W` = 16 gives the full 64 KB size.

Top module: `banked_word_mem`

## Requirements
- R1: A request targets bank `addr[2:1]` and word `addr[ADDR_W-1:1]`. Sequential word addresses, issued one per cycle, are all accepted with `stall` low.
- R2: A read accepted in cycle N shows its word on `rdata` in cycle N+2 only. In every cycle without such a read, `rdata` is zero.
- R3: A write accepted in cycle N is in the array at the end of cycle N+3. A read of the same word accepted in cycle N+4 returns the new value.
- R4: After a request to bank b is accepted in cycle N, `bank_busy[b]` is high in cycles N+1, N+2 and N+3 and low from cycle N+4 unless a new request is accepted. Bit k of `bank_busy` belongs to bank k.
- R5: A valid request to a bank whose busy flag is high raises `stall` in the same cycle. Such a request writes nothing, returns no read data and does not extend the busy window.
- R6: A request to a bank that is not busy is accepted in the cycle right after a request to another bank.
- R7: A request with `addr[0]` = 1, or with `rd_en` and `wr_en` both high, raises `err` in the same cycle. It is not performed, `stall` stays low and no bank becomes busy.
- R8: After reset every busy flag is low, `rdata` is zero, and every word of the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address of the request |
| wdata | input | DATA_W | Data stored by a write |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rdata | output | DATA_W | Read data, two cycles after an accepted read, zero otherwise |
| stall | output | 1 | Request dropped because its bank is busy |
| bank_busy | output | NUM_BANKS | One flag per bank, high while that bank rejects requests |
| err | output | 1 | Misaligned request, or read and write requested together |

## Verification
The bench first fills every word with sequential writes and then reads every word back with sequential reads. This shows that bank interleaving sustains one request per cycle and that each word goes to its own location. Next, the bench sweeps the gap between two requests to the same bank from one to five cycles on every bank. This separates requests that are dropped from requests that are accepted at the edge of the window, and a later read-back proves that a dropped write stored nothing. A directed write followed by a read four cycles later pins the commit time. Misaligned requests and requests with both read and write high are then mixed with a long pseudo-random stream confined to a small address range. This forces frequent bank conflicts, and a cycle-accurate reference model checks the result every cycle.

// File: rtl/bkm_pkg.sv
package bkm_pkg;

   // True when v is a non-zero power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bkm_req_decode.sv
// Splits the request address into bank and word fields. Raises err and
// stall, and produces a one-hot accept strobe for the target bank.
module bkm_req_decode #(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 4
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic                            rd_en,
   input  logic                            wr_en,
   input  logic [NUM_BANKS-1:0]            busy,
   output logic [ADDR_W-2-$clog2(NUM_BANKS):0] word_idx,
   output logic                            err,
   output logic                            stall,
   output logic [NUM_BANKS-1:0]            acc_vec
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);

   logic                 req;
   logic                 ok;
   logic [BANK_BITS-1:0] bank_sel;

   always_comb begin
      req      = rd_en | wr_en;
      err      = req & (addr[0] | (rd_en & wr_en));
      bank_sel = addr[BANK_BITS:1];
      word_idx = addr[ADDR_W-1:BANK_BITS+1];
      stall    = req & ~err & busy[bank_sel];
      ok       = req & ~err & ~stall;
   end

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_acc
      assign acc_vec[k] = ok && (bank_sel == BANK_BITS'(k));
   end

endmodule

// File: rtl/bkm_bank.sv
// One bank. It holds one operation for BUSY_CYCLES cycles: a read is
// looked up in the second cycle, and a write is committed in the last.
module bkm_bank #(
   parameter int DATA_W      = 16,
   parameter int WORD_BITS   = 9,
   parameter int BUSY_CYCLES = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 acc_i,
   input  logic                 is_wr_i,
   input  logic [WORD_BITS-1:0] idx_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic                 busy_o,
   output logic                 rvalid_o,
   output logic [DATA_W-1:0]    rdata_o
);
   localparam int DEPTH = 1 << WORD_BITS;
   localparam int CNT_W = $clog2(BUSY_CYCLES);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BUSY_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [DATA_W-1:0]    store [DEPTH];
   logic [CNT_W-1:0]     cnt;
   logic                 op_wr;
   logic [WORD_BITS-1:0] op_idx;
   logic [DATA_W-1:0]    op_data;
   logic                 rv_q;
   logic [DATA_W-1:0]    rd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         op_wr   <= 1'b0;
         op_idx  <= '0;
         op_data <= '0;
         rv_q    <= 1'b0;
         rd_q    <= '0;
         for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else begin
         rv_q <= 1'b0;
         if (acc_i) begin
            cnt     <= CNT_TOP;
            op_wr   <= is_wr_i;
            op_idx  <= idx_i;
            op_data <= wdata_i;
         end else if (cnt != '0) begin
            cnt <= cnt - CNT_ONE;
         end
         if (cnt == CNT_TOP && !op_wr) begin
            rv_q <= 1'b1;
            rd_q <= store[op_idx];
         end
         if (cnt == CNT_ONE && op_wr) begin
            store[op_idx] <= op_data;
         end
      end
   end

   assign busy_o   = (cnt != '0);
   assign rvalid_o = rv_q;
   assign rdata_o  = rd_q;

endmodule

// File: rtl/bkm_rdata_merge.sv
// Merges the banks' read ports into one output: zero when no bank returns data.
module bkm_rdata_merge #(
   parameter int DATA_W    = 16,
   parameter int NUM_BANKS = 4
) (
   input  logic [NUM_BANKS-1:0]        valid,
   input  logic [NUM_BANKS*DATA_W-1:0] data_flat,
   output logic [DATA_W-1:0]           rdata
);
   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (valid[k]) rdata = rdata | data_flat[k*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 12,
   parameter int NUM_BANKS   = 4,
   parameter int BUSY_CYCLES = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 wr_en,
   input  logic                 rd_en,
   output logic [DATA_W-1:0]    rdata,
   output logic                 stall,
   output logic [NUM_BANKS-1:0] bank_busy,
   output logic                 err
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int WORD_BITS = ADDR_W - 1 - BANK_BITS;

   if (!bkm_pkg::is_pow2(NUM_BANKS)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two");
   end
   if (NUM_BANKS < 2) begin : g_bad_nbanks
      $error("NUM_BANKS must be at least 2");
   end
   if (BUSY_CYCLES < 3) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 3");
   end
   if (WORD_BITS < 1) begin : g_bad_addr
      $error("ADDR_W too small for the bank count");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [WORD_BITS-1:0]        word_idx;
   logic [NUM_BANKS-1:0]        acc_vec;
   logic [NUM_BANKS-1:0]        rd_valid_vec;
   logic [NUM_BANKS*DATA_W-1:0] rd_data_flat;

   bkm_req_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS)
   ) u_decode (
      .addr     (addr),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .busy     (bank_busy),
      .word_idx (word_idx),
      .err      (err),
      .stall    (stall),
      .acc_vec  (acc_vec)
   );

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      bkm_bank #(
         .DATA_W      (DATA_W),
         .WORD_BITS   (WORD_BITS),
         .BUSY_CYCLES (BUSY_CYCLES)
      ) u_bank (
         .clk      (clk),
         .rst      (rst),
         .acc_i    (acc_vec[k]),
         .is_wr_i  (wr_en),
         .idx_i    (word_idx),
         .wdata_i  (wdata),
         .busy_o   (bank_busy[k]),
         .rvalid_o (rd_valid_vec[k]),
         .rdata_o  (rd_data_flat[k*DATA_W +: DATA_W])
      );
   end

   bkm_rdata_merge #(
      .DATA_W    (DATA_W),
      .NUM_BANKS (NUM_BANKS)
   ) u_merge (
      .valid     (rd_valid_vec),
      .data_flat (rd_data_flat),
      .rdata     (rdata)
   );

endmodule

// File: rtl/bkm_check.sv
module bkm_check #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic [ADDR_W-1:0]    addr,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [DATA_W-1:0]    rdata,
   input logic                 stall,
   input logic [NUM_BANKS-1:0] bank_busy,
   input logic                 err,
   input logic [NUM_BANKS-1:0] rd_valid_vec
);
   localparam int BANK_BITS = $clog2(NUM_BANKS);

   logic req, taken;
   assign req   = rd_en | wr_en;
   assign taken = req & ~err & ~stall;

   // R7: read and write together is refused
   assert_both_err_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && wr_en) |-> err);

   // R7: a refused request never also reports a stall
   assert_err_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
      err |-> !stall);

   // R4: the bank of an accepted request is busy in the next cycle
   assert_busy_after_take_R4: assert property (@(posedge clk) disable iff (rst)
      taken |=> bank_busy[$past(addr[BANK_BITS:1])]);

   // R2: an accepted read produces exactly one returning bank two cycles later
   assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (taken && rd_en) |=> ##1 ($countones(rd_valid_vec) == 1));

   // R2: returning read data always stems from a read taken two cycles before
   assert_no_spurious_read_R2: assert property (@(posedge clk) disable iff (rst)
      (rd_valid_vec != '0) |-> $past(rd_en && !wr_en && !addr[0] && !stall, 2));

   // R2: never two banks returning at once
   assert_one_return_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rd_valid_vec));

   // R2: output is zero with no returning read
   assert_rdata_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (rd_valid_vec == '0) |-> (rdata == '0));

   // R5: a busy flag only rises because a request to that bank was taken
   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_rise
      assert_busy_rise_cause_R5: assert property (@(posedge clk) disable iff (rst)
         $rose(bank_busy[k]) |-> $past(taken && (addr[BANK_BITS:1] == BANK_BITS'(k))));
   end

endmodule

bind banked_word_mem bkm_check #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_BANKS (NUM_BANKS)
) u_bkm_check (
   .clk          (clk),
   .rst          (rst),
   .addr         (addr),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .rdata        (rdata),
   .stall        (stall),
   .bank_busy    (bank_busy),
   .err          (err),
   .rd_valid_vec (rd_valid_vec)
);

// File: tb/banked_word_mem_bench.sv
module banked_word_mem_bench;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int NB = 4;
   localparam int BC = 4;
   localparam int NW = 1 << (AW - 1);

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic          wr_en, rd_en;
   logic [DW-1:0] rdata;
   logic          stall, err;
   logic [NB-1:0] bank_busy;

   always #4 clk = ~clk;   // 125 MHz

   banked_word_mem #(.DATA_W(DW), .ADDR_W(AW), .NUM_BANKS(NB), .BUSY_CYCLES(BC)) u_banked_word_mem (
      .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
      .rdata(rdata), .stall(stall), .bank_busy(bank_busy), .err(err));

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model
   logic [DW-1:0] m_mem [NW];
   int            m_cnt [NB];
   logic          m_wr  [NB];
   int            m_widx[NB];
   logic [DW-1:0] m_wdat[NB];
   logic          s0_v, s1_v;
   logic [DW-1:0] s0_d, s1_d;
   string         data_tag;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < NW; i++) m_mem[i] = '0;
      for (int k = 0; k < NB; k++) begin m_cnt[k] = 0; m_wr[k] = 0; m_widx[k] = 0; m_wdat[k] = '0; end
      s0_v = 0; s1_v = 0; s0_d = '0; s1_d = '0;
   endtask

   // Drive one request at the falling edge, check, and advance one clock.
   task automatic step(input logic r, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic e_err, e_stall, take;
      int   b;
      rd_en = r; wr_en = w; addr = a; wdata = d;
      #1;
      b       = int'(a[2:1]);
      e_err   = (r | w) & (a[0] | (r & w));
      e_stall = (r | w) & ~e_err & (m_cnt[b] != 0);
      take    = (r | w) & ~e_err & ~e_stall;
      chk("R7", "err", 32'(err), 32'(e_err));
      chk("R5", "stall", 32'(stall), 32'(e_stall));
      for (int k = 0; k < NB; k++)
         chk("R4", "bank_busy bit", 32'(bank_busy[k]), 32'(m_cnt[k] != 0));
      chk(data_tag, "rdata", 32'(rdata), s1_v ? 32'(s1_d) : 32'(0));
      @(posedge clk);
      for (int k = 0; k < NB; k++) begin
         if (m_cnt[k] == 1 && m_wr[k]) m_mem[m_widx[k]] = m_wdat[k];
         if (m_cnt[k] > 0) m_cnt[k]--;
      end
      s1_v = s0_v; s1_d = s0_d; s0_v = 0;
      if (take) begin
         m_cnt[b] = BC - 1; m_wr[b] = w; m_widx[b] = int'(a >> 1); m_wdat[b] = d;
         if (r) begin s0_v = 1; s0_d = m_mem[int'(a >> 1)]; end
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, '0, '0);
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return DW'((i * 37) ^ 16'h5A00);
   endfunction

   initial begin
      logic [31:0] x;
      rst = 1; rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
      model_reset();
      data_tag = "R8";
      repeat (4) @(negedge clk);
      rst = 0;
      // R8: reset state at the ports
      chk("R8", "bank_busy after reset", 32'(bank_busy), 32'(0));
      chk("R8", "rdata after reset", 32'(rdata), 32'(0));
      // R8: array reads as zero
      for (int i = 0; i < 8; i++) step(1, 0, AW'(i * 2), '0);
      idle(4);

      // R1, R6: full-rate sequential fill then readback
      data_tag = "R1";
      for (int i = 0; i < NW; i++) step(0, 1, AW'(i * 2), pat(i));
      idle(4);
      for (int i = 0; i < NW; i++) step(1, 0, AW'(i * 2), '0);
      idle(4);

      // R5: same-bank gap sweep, dropped writes verified by read-back
      data_tag = "R5";
      for (int gap = 1; gap <= 5; gap++) begin
         for (int b = 0; b < NB; b++) begin
            step(1, 0, AW'(b * 2), '0);
            idle(gap - 1);
            step(0, 1, AW'(b * 2 + 8 * gap), DW'(16'hC000 + gap * 16 + b));
            idle(4);
            step(1, 0, AW'(b * 2 + 8 * gap), '0);
            idle(3);
         end
      end

      // R3: write then read of the same word exactly four cycles later
      data_tag = "R3";
      step(0, 1, AW'(16'h0100), 16'hBEEF);
      idle(3);
      step(1, 0, AW'(16'h0100), '0);
      idle(3);

      // R7: misaligned and read+write requests refused, no effect on array
      data_tag = "R7";
      step(0, 1, AW'(16'h0041), 16'h1111);
      step(1, 1, AW'(16'h0040), 16'h2222);
      step(1, 0, AW'(16'h0043), '0);
      step(1, 0, AW'(16'h0040), '0);
      idle(3);

      // R5, R6: pseudo-random stream over a small range to force conflicts
      data_tag = "R5";
      x = 32'h1234_5678;
      for (int i = 0; i < 4000; i++) begin
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         step(x[0] & x[3], x[1] & x[4], AW'({x[12:8], (x[5] & x[6] & x[7])}), DW'(x[31:16]));
      end
      idle(4);
      data_tag = "R1";
      for (int i = 0; i < 32; i++) step(1, 0, AW'(i * 2), '0);
      idle(4);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule